// File: doc/BRIEF.md
# Interrupt Distributor Global Control Register

This block is the global control word of an interrupt distributor. Software reaches it through a 32-bit register port. It holds three interrupt-group enables and two affinity-routing enables, one routing enable for each security state. The values software writes are held in a staged copy, and reads return that copy. The downstream distributor logic sees a separate delayed copy, which the block exports on its own output pins. That copy catches up a fixed number of cycles after the most recent write.

While a write has not yet reached the downstream copy, bit 31 of the read value is 1. Software can poll this bit before it relies on a change. The safe bring-up sequence is:

1. Set the routing enables.
2. Wait for bit 31 to clear.
3. Turn on the groups.

In full mode the block enforces this order. A write that would raise a routing enable while any group is on leaves that routing bit at 0, and the block flags the write on an error pulse.

A static mode pin selects full or legacy-compatible operation. In legacy-compatible mode the secure group 1 enable is hard-wired to zero and the ordering guard is off. Accesses marked non-secure may only change the non-secure group 1 enable and the non-secure routing enable.

Top module: `dist_ctrl_reg`

## Requirements
- R1: The field positions are: bit 0 = group 0 enable, bit 1 = non-secure group 1 enable, bit 2 = secure group 1 enable, bit 4 = secure routing enable, bit 5 = non-secure routing enable. In full mode a secure write of 0x30 followed by 0x37 reads back 0x37 with its low 31 bits.
- R2: After reset the read value is 0x00000000, and all five downstream enable outputs and `order_err` are 0.
- R3: Bit 31 of `rd_data` reads 1 from the clock edge that accepts a write until DELAY edges have passed with no further write, and reads 0 after that.
- R4: The downstream enable outputs take the staged value on the DELAY-th edge after the last write and hold their old value before it. `rd_data` shows the staged value from the edge after the write.
- R5: A write accepted while bit 31 is 1 updates the staged value and restarts the DELAY-cycle count.
- R6: A write with `wr_secure`=0 changes only bits 1 and 5. Bits 0, 2 and 4 keep their values.
- R7: With `legacy_mode`=1, bit 2 and `dn_grp1s_en` read 0 and writes to bit 2 are ignored. The ordering guard is off, so a write of 0x37 from zero reads back 0x33.
- R8: With `legacy_mode`=0, a write that would move a routing bit from 0 to 1 while any group enable is 1 leaves that routing bit at 0. "Any group enable" covers both the current value and the value the write produces. The other fields still update, and `order_err` is 1 for exactly one cycle after the write edge.
- R9: Bits 3 and 6 to 30 always read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| legacy_mode | input | 1 | Static mode select: 1 = legacy-compatible, 0 = full |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_secure | input | 1 | 1 = secure access, 0 = non-secure |
| wr_data | input | 32 | Write value |
| rd_data | output | 32 | Staged value, with the write-pending flag in bit 31 |
| dn_grp0_en | output | 1 | Delayed group 0 enable |
| dn_grp1ns_en | output | 1 | Delayed non-secure group 1 enable |
| dn_grp1s_en | output | 1 | Delayed secure group 1 enable |
| dn_route_s_en | output | 1 | Delayed secure routing enable |
| dn_route_ns_en | output | 1 | Delayed non-secure routing enable |
| order_err | output | 1 | One-cycle pulse when the ordering guard blocked a write |

## Verification
The checker watches these properties on every cycle:
- reserved bits and the legacy-mode secure group 1 bit stay at zero;
- the non-secure path leaves bits 0, 2 and 4 untouched;
- a routing bit rises only while no group is on;
- the downstream copy changes only on the edge where the pending flag falls.

Only the bench scenarios can show the rest:
- that the downstream copy lands exactly DELAY cycles after the last write;
- that a write during the pending window pushes the update back;
- the concrete readback values of the documented sequences, such as 0x30 then 0x37, and 0x37 reading 0x33 in legacy mode.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int REG_W  = 32;
  localparam int B_G0   = 0;
  localparam int B_G1NS = 1;
  localparam int B_G1S  = 2;
  localparam int B_RTS  = 4;
  localparam int B_RTNS = 5;
  localparam int B_PEND = 31;

  typedef struct packed {
    logic rt_ns;
    logic rt_s;
    logic g1s;
    logic g1ns;
    logic g0;
  } dcr_fields_t;

  function automatic dcr_fields_t dcr_unpack(input logic [REG_W-1:0] v);
    dcr_fields_t f;
    f.g0    = v[B_G0];
    f.g1ns  = v[B_G1NS];
    f.g1s   = v[B_G1S];
    f.rt_s  = v[B_RTS];
    f.rt_ns = v[B_RTNS];
    return f;
  endfunction

  function automatic logic [REG_W-1:0] dcr_pack(input dcr_fields_t f, input logic pend);
    logic [REG_W-1:0] v;
    v         = '0;
    v[B_G0]   = f.g0;
    v[B_G1NS] = f.g1ns;
    v[B_G1S]  = f.g1s;
    v[B_RTS]  = f.rt_s;
    v[B_RTNS] = f.rt_ns;
    v[B_PEND] = pend;
    return v;
  endfunction
endpackage

// File: rtl/dcr_write_filter.sv
module dcr_write_filter
  import dcr_pkg::*;
(
  input  dcr_fields_t      cur,
  input  logic [REG_W-1:0] wdata,
  input  logic             secure,
  input  logic             legacy,
  output dcr_fields_t      nxt,
  output logic             blocked
);
  dcr_fields_t wr;
  dcr_fields_t mask;
  dcr_fields_t cand;
  logic        grp_any;
  logic        guard_on;
  logic        blk_s;
  logic        blk_ns;

  always_comb begin
    wr         = dcr_unpack(wdata);
    mask.g0    = secure;
    mask.g1ns  = 1'b1;
    mask.g1s   = secure & ~legacy;
    mask.rt_s  = secure;
    mask.rt_ns = 1'b1;
    cand       = (cur & ~mask) | (wr & mask);
    grp_any    = cur.g0 | cur.g1ns | cur.g1s | cand.g0 | cand.g1ns | cand.g1s;
    guard_on   = ~legacy & grp_any;
    blk_s      = guard_on & ~cur.rt_s  & cand.rt_s;
    blk_ns     = guard_on & ~cur.rt_ns & cand.rt_ns;
    nxt        = cand;
    if (blk_s)  nxt.rt_s  = 1'b0;
    if (blk_ns) nxt.rt_ns = 1'b0;
    if (legacy) nxt.g1s   = 1'b0;
    blocked    = blk_s | blk_ns;
  end
endmodule

// File: rtl/dcr_settle_timer.sv
module dcr_settle_timer #(
  parameter int DELAY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic pending,
  output logic expire
);
  localparam int CNT_W = $clog2(DELAY + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(DELAY);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else if (start) begin
      cnt     <= LOAD;
      pending <= 1'b1;
    end else if (pending) begin
      cnt <= cnt - ONE;
      if (cnt == ONE) pending <= 1'b0;
    end
  end

  assign expire = pending & ~start & (cnt == ONE);
endmodule

// File: rtl/dcr_shadow.sv
module dcr_shadow
  import dcr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  dcr_fields_t d,
  output dcr_fields_t q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/dist_ctrl_reg.sv
module dist_ctrl_reg
  import dcr_pkg::*;
#(
  parameter int DELAY = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        legacy_mode,
  input  logic        wr_en,
  input  logic        wr_secure,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        dn_grp0_en,
  output logic        dn_grp1ns_en,
  output logic        dn_grp1s_en,
  output logic        dn_route_s_en,
  output logic        dn_route_ns_en,
  output logic        order_err
);
  dcr_fields_t staged;
  dcr_fields_t staged_nxt;
  dcr_fields_t shadow;
  logic        blocked;
  logic        pending;
  logic        expire;

  dcr_write_filter u_filter (
    .cur     (staged),
    .wdata   (wr_data),
    .secure  (wr_secure),
    .legacy  (legacy_mode),
    .nxt     (staged_nxt),
    .blocked (blocked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      staged    <= '0;
      order_err <= 1'b0;
    end else begin
      order_err <= wr_en & blocked;
      if (wr_en) staged <= staged_nxt;
    end
  end

  dcr_settle_timer #(.DELAY(DELAY)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start   (wr_en),
    .pending (pending),
    .expire  (expire)
  );

  dcr_shadow u_shadow (
    .clk  (clk),
    .rst  (rst),
    .load (expire),
    .d    (staged),
    .q    (shadow)
  );

  assign rd_data        = dcr_pack(staged, pending);
  assign dn_grp0_en     = shadow.g0;
  assign dn_grp1ns_en   = shadow.g1ns;
  assign dn_grp1s_en    = shadow.g1s;
  assign dn_route_s_en  = shadow.rt_s;
  assign dn_route_ns_en = shadow.rt_ns;
endmodule

// File: rtl/dcr_checker.sv
module dcr_checker (
  input logic        clk,
  input logic        rst,
  input logic        legacy_mode,
  input logic        wr_en,
  input logic        wr_secure,
  input logic [31:0] rd_data,
  input logic        dn_grp0_en,
  input logic        dn_grp1ns_en,
  input logic        dn_grp1s_en,
  input logic        dn_route_s_en,
  input logic        dn_route_ns_en,
  input logic        order_err
);
  logic [4:0] dn;
  assign dn = {dn_route_ns_en, dn_route_s_en, dn_grp1s_en, dn_grp1ns_en, dn_grp0_en};

  a_r3_pend_after_write: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_data[31]);

  a_r4_dn_moves_on_settle: assert property (@(posedge clk) disable iff (rst)
    !$stable(dn) |-> $fell(rd_data[31]));

  a_r6_nonsec_keeps_bits: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_secure) |=> ($stable(rd_data[0]) && $stable(rd_data[2]) && $stable(rd_data[4])));

  a_r7_legacy_g1s_zero: assert property (@(posedge clk) disable iff (rst)
    legacy_mode |-> (!rd_data[2] && !dn_grp1s_en));

  a_r8_route_rise_clean: assert property (@(posedge clk) disable iff (rst)
    (!legacy_mode && ($rose(rd_data[4]) || $rose(rd_data[5]))) |->
      (rd_data[2:0] == 3'b000 && $past(rd_data[2:0]) == 3'b000));

  a_r8_err_needs_write: assert property (@(posedge clk) disable iff (rst)
    order_err |-> $past(wr_en));

  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_data[30:6] == '0) && !rd_data[3]);
endmodule

bind dist_ctrl_reg dcr_checker u_chk (
  .clk            (clk),
  .rst            (rst),
  .legacy_mode    (legacy_mode),
  .wr_en          (wr_en),
  .wr_secure      (wr_secure),
  .rd_data        (rd_data),
  .dn_grp0_en     (dn_grp0_en),
  .dn_grp1ns_en   (dn_grp1ns_en),
  .dn_grp1s_en    (dn_grp1s_en),
  .dn_route_s_en  (dn_route_s_en),
  .dn_route_ns_en (dn_route_ns_en),
  .order_err      (order_err)
);

// File: tb/dist_ctrl_reg_bench.sv
module dist_ctrl_reg_bench;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        legacy_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_secure = 1'b1;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        dn_grp0_en, dn_grp1ns_en, dn_grp1s_en, dn_route_s_en, dn_route_ns_en;
  logic        order_err;
  int          n_chk = 0;
  int          n_bad = 0;

  always #10 clk = ~clk;

  dist_ctrl_reg #(.DELAY(N)) u_dist_ctrl_reg (
    .clk(clk), .rst(rst), .legacy_mode(legacy_mode), .wr_en(wr_en),
    .wr_secure(wr_secure), .wr_data(wr_data), .rd_data(rd_data),
    .dn_grp0_en(dn_grp0_en), .dn_grp1ns_en(dn_grp1ns_en), .dn_grp1s_en(dn_grp1s_en),
    .dn_route_s_en(dn_route_s_en), .dn_route_ns_en(dn_route_ns_en), .order_err(order_err)
  );

  function automatic logic [5:0] dn_word();
    return {dn_route_ns_en, dn_route_s_en, 1'b0, dn_grp1s_en, dn_grp1ns_en, dn_grp0_en};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic leg);
    @(negedge clk);
    rst = 1'b1;
    legacy_mode = leg;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // one write; returns at the negedge right after the accepting edge
  task automatic wr(input logic [31:0] d, input logic sec);
    wr_data = d;
    wr_secure = sec;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (N) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    check("R2 read", rd_data, 32'h0);
    check("R2 downstream", {26'h0, dn_word()}, 32'h0);
    check("R2 err", {31'h0, order_err}, 32'h0);
  endtask

  task automatic t_full_sequence();
    do_reset(1'b0);
    wr(32'h30, 1'b1);
    check("R3 pending set", rd_data, 32'h8000_0030);
    check("R4 dn old", {26'h0, dn_word()}, 32'h0);
    repeat (N - 1) @(negedge clk);
    check("R3 still pending", {31'h0, rd_data[31]}, 32'h1);
    check("R4 dn before delay", {26'h0, dn_word()}, 32'h0);
    @(negedge clk);
    check("R3 pending clear", rd_data, 32'h30);
    check("R4 dn after delay", {26'h0, dn_word()}, 32'h30);
    wr(32'h37, 1'b1);
    settle();
    check("R1 readback", rd_data, 32'h37);
    check("R1 dn", {26'h0, dn_word()}, 32'h37);
    check("R8 no err on legal order", {31'h0, order_err}, 32'h0);
  endtask

  task automatic t_restart();
    do_reset(1'b0);
    wr(32'h30, 1'b1);
    @(negedge clk);
    wr(32'h31, 1'b1);
    check("R5 staged updated", rd_data, 32'h8000_0031);
    repeat (N - 1) @(negedge clk);
    check("R5 still pending", {31'h0, rd_data[31]}, 32'h1);
    check("R5 dn held", {26'h0, dn_word()}, 32'h0);
    @(negedge clk);
    check("R5 dn final", {26'h0, dn_word()}, 32'h31);
    check("R5 read final", rd_data, 32'h31);
  endtask

  task automatic t_guard();
    do_reset(1'b0);
    wr(32'h37, 1'b1);
    check("R8 routing blocked", rd_data[30:0], 31'h07);
    check("R8 err pulse", {31'h0, order_err}, 32'h1);
    @(negedge clk);
    check("R8 err one cycle", {31'h0, order_err}, 32'h0);
    settle();
    do_reset(1'b0);
    wr(32'h01, 1'b1);
    settle();
    wr(32'h10, 1'b1);
    check("R8 current group blocks", rd_data[30:0], 31'h00);
    check("R8 err current", {31'h0, order_err}, 32'h1);
    settle();
    check("R8 dn", {26'h0, dn_word()}, 32'h0);
  endtask

  task automatic t_nonsecure();
    do_reset(1'b0);
    wr(32'h30, 1'b1);
    settle();
    wr(32'h37, 1'b1);
    settle();
    wr(32'h0, 1'b0);
    settle();
    check("R6 only bits 1,5 cleared", rd_data, 32'h15);
    wr(32'h37, 1'b0);
    settle();
    check("R6 ns write sets bit1 only", rd_data, 32'h17);
    check("R8 ns routing blocked", {31'h0, order_err}, 32'h0);
    check("R6 dn", {26'h0, dn_word()}, 32'h17);
  endtask

  task automatic t_reserved();
    do_reset(1'b0);
    wr(32'hFFFF_FFC8, 1'b1);
    check("R9 reserved ignored", rd_data, 32'h8000_0000);
    settle();
    check("R9 reserved read zero", rd_data, 32'h0);
  endtask

  task automatic t_legacy();
    do_reset(1'b1);
    wr(32'h37, 1'b1);
    settle();
    check("R7 legacy readback", rd_data, 32'h33);
    check("R7 legacy dn g1s", {26'h0, dn_word()}, 32'h33);
    check("R7 no guard err", {31'h0, order_err}, 32'h0);
    do_reset(1'b0);
  endtask

  initial begin
    #3_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_full_sequence();
    t_restart();
    t_guard();
    t_nonsecure();
    t_reserved();
    t_legacy();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule